// File: doc/BRIEF.md
# Pin-Change and External Interrupt Flag Unit

This block watches sixteen general-purpose input pins, grouped into two banks of eight, plus one dedicated external interrupt pin. It raises a pending flag for a bank when any pin in that bank changes level, provided that pin's mask bit and the bank's enable are both set. It raises the external flag on a selectable edge. Every pin passes through its own two-flop synchronizer before detection.

Software reaches three byte-wide registers over a plain register bus: one flag register and two mask registers, one mask register per bank. A flag clears when software writes a one to its bit, or when the CPU's vectoring logic pulses the matching acknowledge line. Each request line is the AND of its flag, its source enable and the global interrupt enable. In level mode the external source keeps no flag: its request comes straight from the synchronized pin being low.

The bus has no back-pressure. A write completes in the cycle `bus_sel_i` and `bus_we_i` are both high. Read data is combinational, so it is valid in the same cycle as the address. All other pins are plain control and status levels.

Top module: `pcx_irq_flags`

## Requirements
- R1: After reset, all three registers read 0x00 and every `irq_o` bit is 0 while `gie_i` is 0.
- R2: Register addresses are: 0 for flags, 1 for the bank-0 mask (pins 7..0), 2 for the bank-1 mask (pins 15..8), and 3 reads 0x00. In the flag register, bit 7 is the bank-1 flag, bit 6 is the bank-0 flag and bit 0 is the external flag. Bits 5..1 always read zero. Both mask registers read back the value written to them.
- R3: A change of level in either direction on pin i sets its bank's flag on the third rising clock edge after the change, when mask bit i and the bank enable are both 1.
- R4: A pin-change event causes no flag when its mask bit is 0 or its bank enable is 0.
- R5: `irq_o` bit 1 (bank 0), bit 2 (bank 1) and bit 0 (external, edge mode) are high only when the flag, the source enable and `gie_i` are all 1.
- R6: A one-cycle pulse on `ack_i` (bit 0 external, bit 1 bank 0, bit 2 bank 1) clears only the matching flag.
- R7: Writing a one to flag bits 7, 6 or 0 clears that flag. Writing a zero leaves the flag unchanged. Writes to bits 5..1 have no effect.
- R8: When a flag is set and cleared in the same cycle, the set wins and the flag reads 1 afterwards.
- R9: `ext_mode_i` selects the external edge mode: 1 for any change, 2 for a falling edge, 3 for a rising edge. The external flag sets only on the selected edge.
- R10: When `ext_mode_i` is 0 (level mode), the external flag is cleared on the next edge and reads 0. `irq_o[0]` is then `gie_i & ext_en_i` AND the synchronized pin being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_pin_i | input | 16 | Pin-change inputs; bits 7..0 are bank 0, bits 15..8 are bank 1 |
| ext_pin_i | input | 1 | External interrupt pin |
| ext_mode_i | input | 2 | External mode: 0 level-low, 1 any change, 2 falling, 3 rising |
| ext_en_i | input | 1 | External source enable |
| bank_en_i | input | 2 | Per-bank pin-change enable |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Acknowledge pulses: bit 0 external, bit 1 bank 0, bit 2 bank 1 |
| bus_sel_i | input | 1 | Register bus select |
| bus_we_i | input | 1 | Register bus write enable |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data; zero when not selected |
| irq_o | output | 3 | Request lines: bit 0 external, bit 1 bank 0, bit 2 bank 1 |

## Verification
The assertions assume that:
- the pins are low while reset is asserted, because the synchronizer and the previous-sample registers reset to zero;
- `ack_i` carries single-cycle pulses;
- `ext_mode_i` changes only while the external pin is stable.

The stimulus follows these rules. It holds every pin low through reset. It drives all inputs on the falling clock edge. It changes the external mode only after the pin has settled for several cycles. It then clears any stale flag before it applies the transition under test.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int NUM_BANKS = 2;
  localparam int REG_W     = 8;

  typedef enum logic [1:0] {
    EXT_LEVEL = 2'd0,
    EXT_ANY   = 2'd1,
    EXT_FALL  = 2'd2,
    EXT_RISE  = 2'd3
  } ext_mode_e;

  localparam logic [1:0] ADDR_FLAGS   = 2'd0;
  localparam logic [1:0] ADDR_MASK_LO = 2'd1;

  // bit positions in the flag register; software decodes these
  localparam int EXT_BIT   = 0;
  localparam int BANK_BIT0 = 6;
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcx_bank.sv
module pcx_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] pin_s,
  input  logic              bank_en,
  input  logic              mask_we,
  input  logic [BANK_W-1:0] mask_wdata,
  input  logic              clr,
  output logic [BANK_W-1:0] mask_q,
  output logic              set_o,
  output logic              flag_q
);
  logic [BANK_W-1:0] prev;
  logic [BANK_W-1:0] moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      mask_q <= '0;
    end else begin
      prev <= pin_s;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign moved = (pin_s ^ prev) & mask_q;
  assign set_o = bank_en & (|moved);

  // a new event outranks any clear arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_o) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end
endmodule

// File: rtl/pcx_ext.sv
module pcx_ext
  import pcx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  ext_mode_e mode,
  input  logic      clr,
  output logic      flag_q,
  output logic      level_act
);
  logic prev;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= pin_s;
  end

  always_comb begin
    unique case (mode)
      EXT_ANY:  hit = pin_s ^ prev;
      EXT_FALL: hit = ~pin_s & prev;
      EXT_RISE: hit = pin_s & ~prev;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (mode == EXT_LEVEL) flag_q <= 1'b0;
    else if (hit)               flag_q <= 1'b1;
    else if (clr)               flag_q <= 1'b0;
  end

  assign level_act = ~pin_s;
endmodule

// File: rtl/pcx_irq_flags.sv
module pcx_irq_flags
  import pcx_pkg::*;
#(
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] chg_pin_i,
  input  logic                        ext_pin_i,
  input  logic [1:0]                  ext_mode_i,
  input  logic                        ext_en_i,
  input  logic [NUM_BANKS-1:0]        bank_en_i,
  input  logic                        gie_i,
  input  logic [NUM_BANKS:0]          ack_i,
  input  logic                        bus_sel_i,
  input  logic                        bus_we_i,
  input  logic [1:0]                  bus_addr_i,
  input  logic [REG_W-1:0]            bus_wdata_i,
  output logic [REG_W-1:0]            bus_rdata_o,
  output logic [NUM_BANKS:0]          irq_o
);
  localparam int NPIN = NUM_BANKS * BANK_W;

  logic [NPIN:0]          synced;
  logic [NPIN-1:0]        chg_s;
  logic                   ext_s;
  logic                   wr_en;
  logic                   w1c;
  logic [NUM_BANKS-1:0]   bank_flag;
  logic [NUM_BANKS-1:0]   bank_set;
  logic [BANK_W-1:0]      bank_mask [NUM_BANKS];
  logic                   ext_flag;
  logic                   ext_level;
  ext_mode_e              mode;

  pcx_sync #(.W(NPIN + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_pin_i, chg_pin_i}),
    .q     (synced)
  );

  assign chg_s = synced[NPIN-1:0];
  assign ext_s = synced[NPIN];
  assign wr_en = bus_sel_i & bus_we_i;
  assign w1c   = wr_en && (bus_addr_i == ADDR_FLAGS);
  assign mode  = ext_mode_e'(ext_mode_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [1:0] MASK_ADDR = ADDR_MASK_LO + 2'(b);

    pcx_bank #(.BANK_W(BANK_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (chg_s[b*BANK_W +: BANK_W]),
      .bank_en    (bank_en_i[b]),
      .mask_we    (wr_en && (bus_addr_i == MASK_ADDR)),
      .mask_wdata (bus_wdata_i[BANK_W-1:0]),
      .clr        (ack_i[b+1] | (w1c & bus_wdata_i[BANK_BIT0+b])),
      .mask_q     (bank_mask[b]),
      .set_o      (bank_set[b]),
      .flag_q     (bank_flag[b])
    );

    assign irq_o[b+1] = gie_i & bank_en_i[b] & bank_flag[b];
  end

  pcx_ext u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s     (ext_s),
    .mode      (mode),
    .clr       (ack_i[0] | (w1c & bus_wdata_i[EXT_BIT])),
    .flag_q    (ext_flag),
    .level_act (ext_level)
  );

  assign irq_o[0] = gie_i & ext_en_i &
                    ((mode == EXT_LEVEL) ? ext_level : ext_flag);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i) begin
      if (bus_addr_i == ADDR_FLAGS) begin
        bus_rdata_o[EXT_BIT] = ext_flag;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata_o[BANK_BIT0+b] = bank_flag[b];
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr_i == ADDR_MASK_LO + 2'(b)) bus_rdata_o[BANK_W-1:0] = bank_mask[b];
      end
    end
  end
endmodule

// File: rtl/pcx_irq_flags_chk.sv
module pcx_irq_flags_chk
  import pcx_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gie_i,
  input logic [NUM_BANKS-1:0] bank_en_i,
  input logic                 ack_b0,
  input logic [1:0]           ext_mode_i,
  input logic [NUM_BANKS:0]   irq_o,
  input logic                 flag_read,
  input logic [4:0]           rsvd_bits,
  input logic [NUM_BANKS-1:0] bank_set,
  input logic [NUM_BANKS-1:0] bank_flag,
  input logic                 ext_flag
);
  assert_no_irq_without_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_o == '0));

  assert_bank0_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[1] |-> (bank_en_i[0] && bank_flag[0]));

  assert_level_clears_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode_i == 2'd0) |=> !ext_flag);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_b0 && !bank_set[0]) |=> !bank_flag[0]);

  assert_set_wins_b0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_set[0] |=> bank_flag[0]);

  assert_set_wins_b1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_set[1] |=> bank_flag[1]);

  assert_disabled_bank0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en_i[0] |=> !$rose(bank_flag[0]));

  assert_disabled_bank1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en_i[1] |=> !$rose(bank_flag[1]));

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_read |-> (rsvd_bits == 5'd0));
endmodule

bind pcx_irq_flags pcx_irq_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gie_i      (gie_i),
  .bank_en_i  (bank_en_i),
  .ack_b0     (ack_i[1]),
  .ext_mode_i (ext_mode_i),
  .irq_o      (irq_o),
  .flag_read  (bus_sel_i && (bus_addr_i == 2'd0)),
  .rsvd_bits  (bus_rdata_o[5:1]),
  .bank_set   (bank_set),
  .bank_flag  (bank_flag),
  .ext_flag   (ext_flag)
);

// File: tb/sim_pcx_irq_flags.sv
module sim_pcx_irq_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chg_pin = '0;
  logic        ext_pin = 1'b0;
  logic [1:0]  ext_mode = 2'd0;
  logic        ext_en = 1'b0;
  logic [1:0]  bank_en = 2'b00;
  logic        gie = 1'b0;
  logic [2:0]  ack = '0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // {mode, pin before, pin after, expected flag}
  localparam logic [4:0] EXT_TAB [8] = '{
    5'b01_0_1_1, 5'b01_1_0_1, 5'b10_0_1_0, 5'b10_1_0_1,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b00_0_1_0, 5'b00_1_0_0
  };

  always #2 clk = ~clk;

  pcx_irq_flags u0 (
    .clk(clk), .rst_n(rst_n), .chg_pin_i(chg_pin), .ext_pin_i(ext_pin),
    .ext_mode_i(ext_mode), .ext_en_i(ext_en), .bank_en_i(bank_en), .gie_i(gie),
    .ack_i(ack), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic peek_irq(output logic [2:0] v);
    @(negedge clk);
    #1 v = irq;
  endtask

  task automatic flip(input int idx);
    @(negedge clk);
    chg_pin[idx] = ~chg_pin[idx];
  endtask

  initial begin
    logic [7:0] v;
    logic [2:0] q;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg after reset", v, 8'h00);
    end
    peek_irq(q); check("R1 irq after reset", {5'd0, q}, 8'h00);

    // R2: masks read back, unused address reads zero
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd(2'd1, v); check("R2 mask lo", v, 8'hA5);
    rd(2'd2, v); check("R2 mask hi", v, 8'h3C);
    rd(2'd3, v); check("R2 addr 3", v, 8'h00);
    // R7: writes to reserved bits have no effect
    wr(2'd0, 8'h3E); rd(2'd0, v); check("R7 reserved write", v, 8'h00);

    // R4: masked pin and disabled bank
    bank_en = 2'b01;
    flip(1); repeat (4) @(posedge clk);
    rd(2'd0, v); check("R4 masked pin", v, 8'h00);
    flip(10); repeat (4) @(posedge clk);
    rd(2'd0, v); check("R4 disabled bank", v, 8'h00);

    // R3: latency of a pin-change event
    flip(0); repeat (2) @(posedge clk);
    rd(2'd0, v); check("R3 not yet set", v, 8'h00);
    @(posedge clk);
    rd(2'd0, v); check("R3 set third edge", v, 8'h40);

    // R5: request gating
    peek_irq(q); check("R5 no gie", {5'd0, q}, 8'h00);
    @(negedge clk) gie = 1'b1;
    peek_irq(q); check("R5 bank0 request", {5'd0, q}, 8'h02);
    @(negedge clk) bank_en = 2'b00;
    peek_irq(q); check("R5 bank disabled", {5'd0, q}, 8'h00);

    // R7: write zero keeps, write one clears
    wr(2'd0, 8'h00); rd(2'd0, v); check("R7 write zero", v, 8'h40);
    wr(2'd0, 8'h40); rd(2'd0, v); check("R7 write one", v, 8'h00);

    // R6: acknowledge clears only its own flag
    bank_en = 2'b11;
    flip(10); repeat (4) @(posedge clk);
    rd(2'd0, v); check("R3 bank1 set", v, 8'h80);
    @(negedge clk) ack = 3'b010;
    @(negedge clk) ack = 3'b000;
    rd(2'd0, v); check("R6 wrong ack", v, 8'h80);
    @(negedge clk) ack = 3'b100;
    @(negedge clk) ack = 3'b000;
    rd(2'd0, v); check("R6 ack clears", v, 8'h00);

    // R8: set and write-one clear in the same cycle
    flip(2); repeat (4) @(posedge clk);
    rd(2'd0, v); check("R8 preset", v, 8'h40);
    flip(2); repeat (2) @(posedge clk);
    wr(2'd0, 8'h40);
    rd(2'd0, v); check("R8 set wins", v, 8'h40);
    wr(2'd0, 8'h40); rd(2'd0, v); check("R8 clear later", v, 8'h00);

    // R9/R10: external edge table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) ext_pin = EXT_TAB[i][2];
      repeat (4) @(posedge clk);
      @(negedge clk) ext_mode = EXT_TAB[i][4:3];
      repeat (2) @(posedge clk);
      wr(2'd0, 8'h01);
      @(negedge clk) ext_pin = EXT_TAB[i][1];
      repeat (4) @(posedge clk);
      rd(2'd0, v);
      check((EXT_TAB[i][4:3] == 2'd0) ? "R10 level flag" : "R9 edge mode",
            v, {7'd0, EXT_TAB[i][0]});
    end

    // R6: external acknowledge
    @(negedge clk) ext_mode = 2'd1;
    @(negedge clk) ext_pin = 1'b1;
    repeat (4) @(posedge clk);
    rd(2'd0, v); check("R9 any change", v, 8'h01);
    @(negedge clk) ack = 3'b001;
    @(negedge clk) ack = 3'b000;
    rd(2'd0, v); check("R6 ext ack", v, 8'h00);

    // R10: level mode forces flag low and follows pin
    @(negedge clk) ext_pin = 1'b0;
    repeat (4) @(posedge clk);
    rd(2'd0, v); check("R9 flag before level", v, 8'h01);
    @(negedge clk) begin ext_mode = 2'd0; ext_en = 1'b1; end
    rd(2'd0, v); check("R10 flag forced", v, 8'h00);
    peek_irq(q); check("R10 low pin request", {5'd0, q}, 8'h01);
    @(negedge clk) ext_pin = 1'b1;
    repeat (3) @(posedge clk);
    peek_irq(q); check("R10 high pin quiet", {5'd0, q}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule